// File: doc/BRIEF.md
# NAND Flash Command and Address Front End

This block is the input stage of a byte-wide NAND flash device. It watches the shared 8-bit I/O bus together with the command-latch, address-latch, write-strobe, read-strobe and chip-enable pins. From these it captures command bytes and address bytes. It keeps a decoded operation code, a 14-bit page (row) address and a 10-bit byte pointer into the 528-byte page. These outputs drive an array-access model, which is not part of this block.

Three read commands share one column address byte and map it onto different parts of the page. Code 00h selects bytes 0 to 255. Code 01h selects bytes 256 to 511. Code 50h selects the 16 spare bytes at 512 to 527. During a sequential read, each read-strobe pulse advances the pointer. When the pointer passes the last column it moves on to the next page.

All pins are sampled on the system clock `clk`. A strobe counts as a rising edge of `we_n` or `re_n` seen between two clock samples.

Top module: `nand_cmd_front`

## Requirements
- R1: After reset, `op` is 0 (idle), `ptr_mode` is 0 (lower half), `col_ptr` is 0 and `row_addr` is 0.
- R2: A command byte is taken on a rising edge of `we_n` while `ce_n` is low, `cle` is high and `ale` is low. The byte sets `op` as follows:
  - 00h, 01h and 50h give 1 (read).
  - 80h gives 2 (data load).
  - 10h gives 3 (program start).
  - 60h gives 4 (erase).
  - 70h gives 5 (status).
  - 90h gives 6 (ID).
  - FFh gives 7 (reset).
  - Any other byte leaves every output unchanged.
- R3: Command 00h sets `ptr_mode`=0 and `col_ptr`=0. Command 01h sets `ptr_mode`=1 and `col_ptr`=256. Command 50h sets `ptr_mode`=2 and `col_ptr`=512.
- R4: An address byte is taken on a rising edge of `we_n` while `ce_n` is low, `ale` is high and `cle` is low.
  - After 00h, 01h, 50h, 80h, 90h or FFh, the first address byte is the column byte. In mode 0 it gives `col_ptr`=byte; in mode 1 it gives 256+byte.
  - The next address byte sets `row_addr[7:0]`.
  - The byte after that sets `row_addr[13:8]` from its bits 5:0.
  - Any further address byte is ignored.
  - After 60h, address input starts at the `row_addr[7:0]` byte.
- R5: In mode 2, the column byte gives `col_ptr` = 512 + byte[3:0]. Bits 7:4 are ignored.
- R6: While `op` is 1, each rising edge of `re_n` with `ce_n` low adds one to `col_ptr`.
- R7: A read-strobe taken at column 527 does three things. It adds one to `row_addr`, wrapping from 16383 to 0. It sets `col_ptr` to 512 in mode 2 and to 0 otherwise. It returns mode 1 to mode 0.
- R8: Commands 10h, 60h and FFh return mode 1 to mode 0 and leave `col_ptr` as it is. Mode 2 is left only by command 00h or 01h.
- R9: While `ce_n` is high, write and read strobes change no output.
- R10: A write strobe with `cle` and `ale` both high changes no output.
- R11: Read strobes do not move the pointer while `op` is not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe; bytes are taken on its rising edge |
| re_n | input | 1 | Read strobe; the pointer advances on its rising edge |
| io_in | input | 8 | Shared command, address and data byte |
| op | output | 3 | Decoded operation code |
| ptr_mode | output | 2 | Page region: 0 lower half, 1 upper half, 2 spare |
| col_ptr | output | 10 | Current byte within the page, 0 to 527 |
| row_addr | output | 14 | Page address |

## Verification
All state sits directly behind the outputs, so a wrong internal state shows at the ports one clock after the strobe that caused it.

The hidden address-cycle counter is the exception. A wrong count stays invisible until the next address byte arrives. That byte then lands in the wrong field, or a fourth byte overwrites the page address.

A wrong region flag shows up later as well. It appears on the next column byte or at the next page crossing, as a base offset of 256 or 512 that should not be there.

// File: rtl/nand_cmd_front.sv
module nand_cmd_front #(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int ROW_W       = 14,
  localparam int COL_W      = $clog2(MAIN_BYTES + SPARE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             we_n,
  input  logic             re_n,
  input  logic [7:0]       io_in,
  output logic [2:0]       op,
  output logic [1:0]       ptr_mode,
  output logic [COL_W-1:0] col_ptr,
  output logic [ROW_W-1:0] row_addr
);
  localparam int HALF     = MAIN_BYTES / 2;
  localparam int LAST_COL = MAIN_BYTES + SPARE_BYTES - 1;
  localparam int SPARE_W  = $clog2(SPARE_BYTES);
  localparam int HI_W     = ROW_W - 8;

  localparam logic [1:0] M_LO = 2'd0, M_HI = 2'd1, M_SP = 2'd2;
  localparam logic [2:0] OP_IDLE = 3'd0, OP_READ = 3'd1, OP_LOAD = 3'd2, OP_PROG = 3'd3,
                         OP_ERASE = 3'd4, OP_STAT = 3'd5, OP_ID = 3'd6, OP_RST = 3'd7;

  logic       we_q, re_q;
  logic [1:0] aidx;

  wire we_rise = !ce_n && we_n && !we_q;
  wire re_rise = !ce_n && re_n && !re_q;
  wire cmd_stb = we_rise && cle && !ale;
  wire adr_stb = we_rise && ale && !cle;
  wire seq_stb = re_rise && (op == OP_READ);
  wire at_end  = (col_ptr == COL_W'(LAST_COL));

  wire [COL_W-1:0] col_base = (ptr_mode == M_HI) ? COL_W'(HALF) : '0;
  wire [COL_W-1:0] col_load = (ptr_mode == M_SP)
                              ? COL_W'(MAIN_BYTES) + COL_W'(io_in[SPARE_W-1:0])
                              : col_base + COL_W'(io_in);
  wire [1:0] mode_drop = (ptr_mode == M_HI) ? M_LO : ptr_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q     <= 1'b1;
      re_q     <= 1'b1;
      aidx     <= 2'd0;
      op       <= OP_IDLE;
      ptr_mode <= M_LO;
      col_ptr  <= '0;
      row_addr <= '0;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
      if (cmd_stb) begin
        case (io_in)
          8'h00: begin op <= OP_READ; ptr_mode <= M_LO; col_ptr <= '0; aidx <= 2'd0; end
          8'h01: begin op <= OP_READ; ptr_mode <= M_HI; col_ptr <= COL_W'(HALF); aidx <= 2'd0; end
          8'h50: begin op <= OP_READ; ptr_mode <= M_SP; col_ptr <= COL_W'(MAIN_BYTES); aidx <= 2'd0; end
          8'h80: begin op <= OP_LOAD; aidx <= 2'd0; end
          8'h10: begin op <= OP_PROG; ptr_mode <= mode_drop; end
          8'h60: begin op <= OP_ERASE; ptr_mode <= mode_drop; aidx <= 2'd1; end
          8'h70: op <= OP_STAT;
          8'h90: begin op <= OP_ID; aidx <= 2'd0; end
          8'hFF: begin op <= OP_RST; ptr_mode <= mode_drop; aidx <= 2'd0; end
          default: ;
        endcase
      end else if (adr_stb) begin
        case (aidx)
          2'd0: begin col_ptr <= col_load; aidx <= 2'd1; end
          2'd1: begin row_addr[7:0] <= io_in; aidx <= 2'd2; end
          2'd2: begin row_addr[ROW_W-1:8] <= io_in[HI_W-1:0]; aidx <= 2'd3; end
          default: ;
        endcase
      end else if (seq_stb) begin
        if (at_end) begin
          row_addr <= row_addr + 1'b1;
          col_ptr  <= (ptr_mode == M_SP) ? COL_W'(MAIN_BYTES) : '0;
          ptr_mode <= mode_drop;
        end else begin
          col_ptr <= col_ptr + 1'b1;
        end
      end
    end
  end

  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    col_ptr <= COL_W'(LAST_COL)); // R7
  AST_HI_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_mode == M_HI |-> col_ptr >= COL_W'(HALF)); // R3
  AST_SPARE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_mode == M_SP |-> col_ptr >= COL_W'(MAIN_BYTES)); // R5
  AST_CE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> $stable(col_ptr) && $stable(row_addr) && $stable(ptr_mode) && $stable(op)); // R9
  AST_BOTH_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (we_rise && cle && ale && !re_rise) |=>
      $stable(col_ptr) && $stable(row_addr) && $stable(ptr_mode) && $stable(op)); // R10
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_stb && at_end && !we_rise) |=> row_addr == $past(row_addr) + 1'b1); // R7
endmodule

// File: tb/nand_cmd_front_test.sv
module nand_cmd_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 36;

  logic clk = 0, rst_n = 0, ce_n = 0, cle = 0, ale = 0, we_n = 1, re_n = 1;
  logic [7:0] io_in = 8'h00;
  logic [2:0] op;
  logic [1:0] ptr_mode;
  logic [9:0] col_ptr;
  logic [13:0] row_addr;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_cmd_front uut (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .io_in(io_in), .op(op), .ptr_mode(ptr_mode),
    .col_ptr(col_ptr), .row_addr(row_addr));

  typedef struct packed {
    logic k; logic c; logic a; logic e; logic [7:0] d; logic [3:0] req;
    logic [2:0] op; logic [1:0] m; logic [9:0] col; logic [13:0] row;
  } vec_t;

  function automatic vec_t C(logic [7:0] d, int r, int o, int m, int col, int row);
    return '{1'b0, 1'b1, 1'b0, 1'b0, d, 4'(r), 3'(o), 2'(m), 10'(col), 14'(row)};
  endfunction
  function automatic vec_t A(logic [7:0] d, int r, int o, int m, int col, int row);
    return '{1'b0, 1'b0, 1'b1, 1'b0, d, 4'(r), 3'(o), 2'(m), 10'(col), 14'(row)};
  endfunction
  function automatic vec_t S(int r, int o, int m, int col, int row);
    return '{1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 4'(r), 3'(o), 2'(m), 10'(col), 14'(row)};
  endfunction
  function automatic vec_t X(logic c, logic a, logic e, logic [7:0] d, int r, int o, int m, int col, int row);
    return '{1'b0, c, a, e, d, 4'(r), 3'(o), 2'(m), 10'(col), 14'(row)};
  endfunction

  localparam vec_t TBL [NV] = '{
    C(8'h00, 3, 1, 0, 0, 0),            // R3
    A(8'h10, 4, 1, 0, 16, 0),           // R4 column byte
    A(8'h34, 4, 1, 0, 16, 'h34),        // R4 row low
    A(8'hFF, 4, 1, 0, 16, 'h3F34),      // R4 row high
    A(8'h77, 4, 1, 0, 16, 'h3F34),      // R4 fourth cycle ignored
    S(6, 1, 0, 17, 'h3F34),             // R6
    C(8'h01, 3, 1, 1, 256, 'h3F34),     // R3
    A(8'hFF, 4, 1, 1, 511, 'h3F34),     // R4 upper half
    A(8'h00, 4, 1, 1, 511, 'h3F00),
    A(8'h00, 4, 1, 1, 511, 0),
    S(6, 1, 1, 512, 0),                 // R6
    C(8'h50, 3, 1, 2, 512, 0),          // R3
    A(8'hFE, 5, 1, 2, 526, 0),          // R5
    A(8'hFF, 4, 1, 2, 526, 'hFF),
    A(8'hFF, 4, 1, 2, 526, 'h3FFF),
    S(6, 1, 2, 527, 'h3FFF),            // R6
    S(7, 1, 2, 512, 0),                 // R7 spare wrap, row wraps
    C(8'h10, 8, 3, 2, 512, 0),          // R8 spare kept
    C(8'h70, 2, 5, 2, 512, 0),          // R2
    S(11, 5, 2, 512, 0),                // R11
    C(8'h00, 3, 1, 0, 0, 0),            // R3
    C(8'h01, 3, 1, 1, 256, 0),
    C(8'h60, 8, 4, 0, 256, 0),          // R8
    A(8'h12, 4, 4, 0, 256, 'h12),       // R4 erase starts at row
    A(8'h05, 4, 4, 0, 256, 'h512),
    X(1'b1, 1'b1, 1'b0, 8'h00, 10, 4, 0, 256, 'h512), // R10
    X(1'b1, 1'b0, 1'b1, 8'h01, 9, 4, 0, 256, 'h512),  // R9
    C(8'hAB, 2, 4, 0, 256, 'h512),      // R2 unknown ignored
    C(8'hFF, 8, 7, 0, 256, 'h512),
    C(8'h01, 3, 1, 1, 256, 'h512),
    C(8'hFF, 8, 7, 0, 256, 'h512),      // R8
    C(8'h80, 2, 2, 0, 256, 'h512),      // R2
    A(8'h05, 4, 2, 0, 5, 'h512),
    A(8'h01, 4, 2, 0, 5, 'h501),
    A(8'h00, 4, 2, 0, 5, 'h001),
    C(8'h90, 2, 6, 0, 5, 1)             // R2
  };

  task automatic wr(input logic c, input logic a, input logic e, input logic [7:0] d);
    @(negedge clk); cle = c; ale = a; ce_n = e; io_in = d; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); cle = 0; ale = 0; ce_n = 0;
  endtask

  task automatic rd(input logic e);
    @(negedge clk); ce_n = e; re_n = 0;
    @(negedge clk); re_n = 1;
    @(negedge clk); ce_n = 0;
  endtask

  task automatic chk(input int r, input logic [2:0] eo, input logic [1:0] em,
                     input logic [9:0] ec, input logic [13:0] er);
    checks++;
    if (op !== eo || ptr_mode !== em || col_ptr !== ec || row_addr !== er) begin
      errors++;
      $display("FAIL R%0d: op=%0d mode=%0d col=%0d row=%0h, expected op=%0d mode=%0d col=%0d row=%0h",
               r, op, ptr_mode, col_ptr, row_addr, eo, em, ec, er);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(1, 0, 0, 0, 0); // R1
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].k) rd(TBL[i].e);
      else wr(TBL[i].c, TBL[i].a, TBL[i].e, TBL[i].d);
      chk(TBL[i].req, TBL[i].op, TBL[i].m, TBL[i].col, TBL[i].row);
    end
    // R7: upper-half read runs through spare and returns to lower half on next page
    wr(1, 0, 0, 8'h01); wr(0, 1, 0, 8'hFF); wr(0, 1, 0, 8'h00); wr(0, 1, 0, 8'h00);
    chk(4, 1, 1, 511, 0);
    for (int i = 0; i < 16; i++) rd(0);
    chk(6, 1, 1, 527, 0);
    rd(0);
    chk(7, 1, 0, 0, 1);
    rd(1);
    chk(9, 1, 0, 0, 1); // R9 read strobe with chip disabled
    rd(0);
    chk(6, 1, 0, 1, 1);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(1, 0, 0, 0, 0); // R1 reset mid-run
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule